// File: doc/BRIEF.md
# Selectable Ratio Clock Output Divider

This block sits behind a frequency synthesizer. It picks the clock that feeds the divider: the synthesizer's oscillator clock in normal operation, or an auxiliary clock when the loop is bypassed. It divides that clock by one of four ratios named by a 2-bit code. The result drives a set of complementary output pairs, all carrying the same waveform. A second select picks the reference that is passed on to the synthesizer: either the crystal clock or the auxiliary clock.

The output has a 50% duty cycle for every ratio. For odd ratios, a state captured on the falling edge extends the high phase by half an input period. A new ratio code takes effect only where a divider period ends, so a change never cuts a pulse short. An active-high master reset parks every pair at once, with the true side low and the inverted side high. Release is synchronised to the selected divider clock, so the first output edge after reset falls at a fixed cycle. With every select input at 0, the block divides the oscillator clock by 3 and forwards the crystal clock as reference.

Top module: `clkdiv_top`

## Requirements
- R1: Ratio code 2'b00 divides by 3, 2'b01 by 4, 2'b10 by 6 and 2'b11 by 12. The output period is the ratio times the period of the selected divider clock.
- R2: The true output is high for exactly half the output period: ratio/2 input periods for even ratios and 1.5 input periods for the ratio of 3.
- R3: While `master_rst` is 1, every `q_p` bit is 0 and every `q_n` bit is 1. This takes effect without waiting for a clock edge.
- R4: After `master_rst` falls, the first rising edge of `q_p` comes with the third rising edge of the selected divider clock. It uses the ratio coded at that moment.
- R5: A change of `ratio_code` is taken only at the rising edge that ends the current output period. That period completes with its old ratio, and no high or low pulse is shorter than 1.5 input periods.
- R6: With `pll_bypass` at 0 the divider is clocked by `vco_clk`. With `pll_bypass` at 1 it is clocked by `aux_clk`. The bypass select is changed only while `master_rst` is 1.
- R7: `pll_ref_clk` follows `xtal_clk` when `ref_src_sel` is 0 and `aux_clk` when it is 1.
- R8: All `q_p` bits are identical, and `q_n` is the bitwise complement of `q_p`.
- R9: With every select input at 0, the block divides `vco_clk` by 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| master_rst | input | 1 | Active-high reset: clears the divider and parks the pairs |
| pll_bypass | input | 1 | 0: divide the oscillator clock; 1: divide the auxiliary clock |
| ref_src_sel | input | 1 | 0: crystal clock as reference; 1: auxiliary clock as reference |
| ratio_code | input | 2 | Division ratio code |
| vco_clk | input | 1 | Synthesizer oscillator clock |
| xtal_clk | input | 1 | Crystal oscillator clock |
| aux_clk | input | 1 | External auxiliary clock |
| pll_ref_clk | output | 1 | Reference clock forwarded to the synthesizer |
| q_p | output | NUM_PAIRS | True side of each output pair |
| q_n | output | NUM_PAIRS | Inverted side of each output pair |

## Verification
Each of the four ratio codes is measured on both divider sources. Because the two sources have unrelated periods, a source-mux fault shows up as a wrong period, not as a plausible one. Measuring the high time separately from the period separates a wrong count limit from a wrong duty split; the 1.5-period high time of the odd ratio exposes a missing falling-edge stage. Ratio changes are made at random phases and in two directed extreme transitions (12 to 3 and 3 to 12), while a monitor records the narrowest pulse. This distinguishes boundary-aligned loading from immediate loading. Counting input edges from reset release to the first output edge pins down the synchroniser depth and the starting count.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Ratio chosen by the 2-bit code; the four candidates come from parameters.
  function automatic int unsigned pick_ratio(input logic [1:0] code,
                                             input int unsigned r0,
                                             input int unsigned r1,
                                             input int unsigned r2,
                                             input int unsigned r3);
    case (code)
      2'd0:    return r0;
      2'd1:    return r1;
      2'd2:    return r2;
      default: return r3;
    endcase
  endfunction

  // Number of whole input periods the rising-edge state stays high.
  function automatic int unsigned high_slots(input int unsigned ratio);
    return ratio / 2;
  endfunction

  // Odd ratios need the extra half period from the falling-edge state.
  function automatic bit ratio_is_odd(input int unsigned ratio);
    return (ratio % 2) == 1;
  endfunction

  function automatic int unsigned max_of4(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned c,
                                          input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/clkdiv_src_mux.sv
module clkdiv_src_mux (
  input  logic vco_clk,
  input  logic xtal_clk,
  input  logic aux_clk,
  input  logic pll_bypass,
  input  logic ref_src_sel,
  output logic div_clk,
  output logic pll_ref_clk
);

  // Divider source: oscillator in normal mode, auxiliary clock in bypass.
  assign div_clk     = pll_bypass  ? aux_clk : vco_clk;
  // Reference source forwarded to the synthesizer.
  assign pll_ref_clk = ref_src_sel ? aux_clk : xtal_clk;

endmodule

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic rst_n
);

  logic [STAGES-1:0] sh_q;

  // Asserts at once, releases after STAGES rising edges of clk.
  always_ff @(posedge clk or posedge arst) begin
    if (arst) sh_q <= '0;
    else      sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sh_q[STAGES-1];

endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
  import clkdiv_pkg::*;
#(
  parameter int unsigned RATIO_0 = 3,
  parameter int unsigned RATIO_1 = 4,
  parameter int unsigned RATIO_2 = 6,
  parameter int unsigned RATIO_3 = 12,
  parameter int unsigned RW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ratio_code,
  output logic          clk_out,
  output logic [RW-1:0] cnt_o,
  output logic [RW-1:0] ratio_o,
  output logic          wrap_o,
  output logic          started_o
);

  logic [RW-1:0] cnt_q, ratio_q, sel_ratio, nxt_cnt, nxt_ratio;
  logic          started_q, pos_q, odd_q, neg_q, wrap;

  assign sel_ratio = RW'(pick_ratio(ratio_code, RATIO_0, RATIO_1, RATIO_2, RATIO_3));
  assign wrap      = (cnt_q == (ratio_q - RW'(1)));

  // The first active edge and every period end load the ratio from the code.
  always_comb begin
    if (!started_q || wrap) begin
      nxt_ratio = sel_ratio;
      nxt_cnt   = '0;
    end else begin
      nxt_ratio = ratio_q;
      nxt_cnt   = cnt_q + RW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      ratio_q   <= RW'(RATIO_0);
      started_q <= 1'b0;
      pos_q     <= 1'b0;
      odd_q     <= 1'b0;
    end else begin
      started_q <= 1'b1;
      cnt_q     <= nxt_cnt;
      ratio_q   <= nxt_ratio;
      pos_q     <= (nxt_cnt < RW'(high_slots(32'(nxt_ratio))));
      odd_q     <= ratio_is_odd(32'(nxt_ratio));
    end
  end

  // Half-period extension for odd ratios.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= 1'b0;
    else        neg_q <= pos_q & odd_q;
  end

  assign clk_out   = pos_q | neg_q;
  assign cnt_o     = cnt_q;
  assign ratio_o   = ratio_q;
  assign wrap_o    = wrap;
  assign started_o = started_q;

endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
  import clkdiv_pkg::*;
#(
  parameter int unsigned NUM_PAIRS   = 2,
  parameter int unsigned RATIO_0     = 3,
  parameter int unsigned RATIO_1     = 4,
  parameter int unsigned RATIO_2     = 6,
  parameter int unsigned RATIO_3     = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 master_rst,
  input  logic                 pll_bypass,
  input  logic                 ref_src_sel,
  input  logic [1:0]           ratio_code,
  input  logic                 vco_clk,
  input  logic                 xtal_clk,
  input  logic                 aux_clk,
  output logic                 pll_ref_clk,
  output logic [NUM_PAIRS-1:0] q_p,
  output logic [NUM_PAIRS-1:0] q_n
);

  localparam int unsigned MAX_RATIO = max_of4(RATIO_0, RATIO_1, RATIO_2, RATIO_3);
  localparam int unsigned RW        = $clog2(MAX_RATIO + 1);

  // Named internal events, brought out for the bound checker.
  logic          div_clk;
  logic          core_rst_n;
  logic          clk_out;
  logic [RW-1:0] cnt;
  logic [RW-1:0] ratio_q;
  logic          wrap;
  logic          started;

  clkdiv_src_mux src_i (
    .vco_clk     (vco_clk),
    .xtal_clk    (xtal_clk),
    .aux_clk     (aux_clk),
    .pll_bypass  (pll_bypass),
    .ref_src_sel (ref_src_sel),
    .div_clk     (div_clk),
    .pll_ref_clk (pll_ref_clk)
  );

  clkdiv_rst_sync #(.STAGES(SYNC_STAGES)) rsync_i (
    .clk   (div_clk),
    .arst  (master_rst),
    .rst_n (core_rst_n)
  );

  clkdiv_core #(
    .RATIO_0 (RATIO_0),
    .RATIO_1 (RATIO_1),
    .RATIO_2 (RATIO_2),
    .RATIO_3 (RATIO_3),
    .RW      (RW)
  ) core_i (
    .clk        (div_clk),
    .rst_n      (core_rst_n),
    .ratio_code (ratio_code),
    .clk_out    (clk_out),
    .cnt_o      (cnt),
    .ratio_o    (ratio_q),
    .wrap_o     (wrap),
    .started_o  (started)
  );

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    assign q_p[g] = clk_out;
    assign q_n[g] = ~clk_out;
  end

endmodule

// File: rtl/clkdiv_top_chk.sv
module clkdiv_top_chk
  import clkdiv_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 2,
  parameter int unsigned RATIO_0   = 3,
  parameter int unsigned RATIO_1   = 4,
  parameter int unsigned RATIO_2   = 6,
  parameter int unsigned RATIO_3   = 12,
  parameter int unsigned RW        = 4
) (
  input logic                 div_clk,
  input logic                 core_rst_n,
  input logic [1:0]           ratio_code,
  input logic [NUM_PAIRS-1:0] q_p,
  input logic [NUM_PAIRS-1:0] q_n,
  input logic                 clk_out,
  input logic [RW-1:0]        cnt,
  input logic [RW-1:0]        ratio_q,
  input logic                 wrap,
  input logic                 started
);

  AST_PARK_IN_RESET: assert property (@(posedge div_clk) disable iff (core_rst_n)
    (q_p == '0) && (q_n == '1)) else $error("pairs not parked"); // R3

  AST_PAIR_COMPL: assert property (@(posedge div_clk) disable iff (!core_rst_n)
    (q_n == ~q_p) && ((q_p == '0) || (q_p == '1))) else $error("pair mismatch"); // R8

  AST_CNT_BOUND: assert property (@(posedge div_clk) disable iff (!core_rst_n)
    cnt < ratio_q) else $error("count beyond ratio"); // R1

  AST_RATIO_HOLD: assert property (@(posedge div_clk) disable iff (!core_rst_n)
    (started && !wrap) |=> $stable(ratio_q)) else $error("ratio changed mid period"); // R5

  AST_RATIO_LOAD: assert property (@(posedge div_clk) disable iff (!core_rst_n)
    (started && wrap) |=> (ratio_q == RW'(pick_ratio($past(ratio_code),
                                 RATIO_0, RATIO_1, RATIO_2, RATIO_3))))
    else $error("ratio not loaded at boundary"); // R1

  AST_FIRST_RISE: assert property (@(posedge div_clk) disable iff (!core_rst_n)
    !started |=> clk_out) else $error("first rise missing"); // R4

endmodule

bind clkdiv_top clkdiv_top_chk #(
  .NUM_PAIRS (NUM_PAIRS),
  .RATIO_0   (RATIO_0),
  .RATIO_1   (RATIO_1),
  .RATIO_2   (RATIO_2),
  .RATIO_3   (RATIO_3),
  .RW        (RW)
) chk_i (
  .div_clk    (div_clk),
  .core_rst_n (core_rst_n),
  .ratio_code (ratio_code),
  .q_p        (q_p),
  .q_n        (q_n),
  .clk_out    (clk_out),
  .cnt        (cnt),
  .ratio_q    (ratio_q),
  .wrap       (wrap),
  .started    (started)
);

// File: tb/clkdiv_top_tb_top.sv
module clkdiv_top_tb_top;

  localparam int CLK_PERIOD  = 20;
  localparam int AUX_PERIOD  = 28;
  localparam int XTAL_PERIOD = 76;

  logic       master_rst  = 1'b1;
  logic       pll_bypass  = 1'b0;
  logic       ref_src_sel = 1'b0;
  logic [1:0] ratio_code  = 2'b00;
  logic       vco_clk = 1'b0, xtal_clk = 1'b0, aux_clk = 1'b0;
  logic       pll_ref_clk;
  logic [1:0] q_p, q_n;

  int  errors = 0;
  int  checks = 0;
  real last_edge = 0.0;
  real min_w = 1.0e9;
  real w = 0.0;
  bit  mon_en = 1'b0;

  clkdiv_top dut_i (
    .master_rst  (master_rst),
    .pll_bypass  (pll_bypass),
    .ref_src_sel (ref_src_sel),
    .ratio_code  (ratio_code),
    .vco_clk     (vco_clk),
    .xtal_clk    (xtal_clk),
    .aux_clk     (aux_clk),
    .pll_ref_clk (pll_ref_clk),
    .q_p         (q_p),
    .q_n         (q_n)
  );

  initial forever #(CLK_PERIOD/2)  vco_clk  = ~vco_clk;
  initial forever #(AUX_PERIOD/2)  aux_clk  = ~aux_clk;
  initial forever #(XTAL_PERIOD/2) xtal_clk = ~xtal_clk;

  function automatic int exp_ratio(input logic [1:0] c);
    case (c)
      2'd0:    return 3;
      2'd1:    return 4;
      2'd2:    return 6;
      default: return 12;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0.2f expected=%0.2f", req, what, act, exp);
    end
  endtask

  // Narrowest pulse seen on the true output while monitoring is on.
  always @(q_p[0]) begin
    if (mon_en) begin
      w = $realtime - last_edge;
      if (w < min_w) min_w = w;
    end
    last_edge = $realtime;
  end

  task automatic measure(output real per, output real hi);
    real t1, t2, t3;
    @(posedge q_p[0]); t1 = $realtime;
    #1;
    check((q_p[1] == q_p[0]) && (q_n == ~q_p), "R8", "pair complement", real'(q_n), real'(~q_p));
    @(negedge q_p[0]); t2 = $realtime;
    @(posedge q_p[0]); t3 = $realtime;
    per = t3 - t1;
    hi  = t2 - t1;
  endtask

  task automatic check_div(input int tsrc, input string tag);
    real per, hi, n;
    n = real'(exp_ratio(ratio_code));
    measure(per, hi);
    check(per == n * tsrc, "R1", {tag, " period"}, per, n * tsrc);
    check(hi == n * tsrc / 2.0, "R2", {tag, " high time"}, hi, n * tsrc / 2.0);
  endtask

  task automatic set_code(input logic [1:0] c);
    ratio_code = c;
    @(posedge q_p[0]);
  endtask

  task automatic check_park(input string what);
    check((q_p == 2'b00) && (q_n == 2'b11), "R3", what, real'(q_p), 0.0);
  endtask

  task automatic check_ref(input bit sel);
    int bad = 0;
    ref_src_sel = sel;
    for (int i = 0; i < 16; i++) begin
      @(posedge vco_clk); #5;
      if (pll_ref_clk !== (sel ? aux_clk : xtal_clk)) bad++;
    end
    check(bad == 0, "R7", sel ? "reference follows aux" : "reference follows crystal", bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    real per, hi, t1, t2, t3;
    void'($urandom(32'h1c5a));

    // Reset state and reference mux
    #(3 * CLK_PERIOD + 1);
    check_park("parked while reset held");
    check_ref(1'b0);
    check_ref(1'b1);
    ref_src_sel = 1'b0;

    // Release with all selects at 0: first rise on third vco edge (R4)
    @(negedge vco_clk); #1 master_rst = 1'b0;
    repeat (2) @(posedge vco_clk);
    #1 check(q_p == 2'b00, "R4", "low before third edge", real'(q_p), 0.0);
    @(posedge vco_clk);
    #1 check(q_p == 2'b11, "R4", "high at third edge", real'(q_p), 3.0);
    measure(per, hi);
    check(per == 3.0 * CLK_PERIOD, "R9", "default divide by 3", per, 3.0 * CLK_PERIOD);

    // Every code on the oscillator clock (R1, R2)
    for (int c = 0; c < 4; c++) begin
      set_code(2'(c));
      check_div(CLK_PERIOD, "vco");
    end

    // Directed boundary: period in progress keeps its old ratio (R5)
    set_code(2'd3);
    @(posedge q_p[0]); t1 = $realtime;
    #3 ratio_code = 2'd0;
    @(negedge q_p[0]); t2 = $realtime;
    @(posedge q_p[0]); t3 = $realtime;
    check(t3 - t1 == 12.0 * CLK_PERIOD, "R5", "old ratio completes", t3 - t1, 12.0 * CLK_PERIOD);
    check(t2 - t1 == 6.0 * CLK_PERIOD, "R5", "old high time kept", t2 - t1, 6.0 * CLK_PERIOD);
    check_div(CLK_PERIOD, "after 12 to 3");
    ratio_code = 2'd3;
    @(posedge q_p[0]);
    check_div(CLK_PERIOD, "after 3 to 12");

    // Random ratio changes at random phases with a runt monitor (R5)
    @(posedge q_p[0]);
    min_w  = 1.0e9;
    mon_en = 1'b1;
    for (int i = 0; i < 24; i++) begin
      repeat ($urandom % 30) @(posedge vco_clk);
      #3 ratio_code = 2'($urandom % 4);
      @(posedge q_p[0]);
      check_div(CLK_PERIOD, "random change");
    end
    mon_en = 1'b0;
    check(min_w >= 1.5 * CLK_PERIOD, "R5", "no runt pulse", min_w, 1.5 * CLK_PERIOD);

    // Asynchronous reset in the middle of a high phase (R3)
    @(posedge q_p[0]);
    #3 master_rst = 1'b1;
    #1 check_park("parked without clock edge");
    repeat (10) @(posedge vco_clk);
    #1 check_park("still parked after edges");

    // Bypass: auxiliary clock drives the divider (R6, R4)
    pll_bypass = 1'b1;
    ratio_code = 2'd1;
    repeat (4) @(posedge aux_clk);
    @(negedge aux_clk); #1 master_rst = 1'b0;
    repeat (2) @(posedge aux_clk);
    #1 check(q_p == 2'b00, "R4", "bypass low before third edge", real'(q_p), 0.0);
    @(posedge aux_clk);
    #1 check(q_p == 2'b11, "R4", "bypass high at third edge", real'(q_p), 3.0);
    for (int c = 0; c < 4; c++) begin
      set_code(2'(3 - c));
      check_div(AUX_PERIOD, "R6 aux source");
    end

    // Back to the oscillator through reset (R6)
    master_rst = 1'b1;
    #(2 * CLK_PERIOD + 1);
    pll_bypass = 1'b0;
    ratio_code = 2'd2;
    @(negedge vco_clk); #1 master_rst = 1'b0;
    @(posedge q_p[0]);
    check_div(CLK_PERIOD, "R6 vco source");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule